// File: doc/BRIEF.md
# Burst beat address sequencer

This block turns one burst request into the address of every data beat of that burst. A request carries a start address, a 4-bit length code, a 3-bit size code and a 2-bit kind code. The block takes it on a one-cycle start pulse while idle. It then presents the current beat's address, index and final-beat flag. Each advance pulse moves it to the next beat. After the final beat is consumed it is idle again.

Three kinds are generated. A fixed burst repeats its start address. An incrementing burst steps by the beat width. A wrapping burst stays inside an aligned window whose size is the whole burst length, and the block reports the bounds of that window. A request with the reserved kind code is refused, and so is a wrapping request whose start address is not a multiple of the beat width. A refused request raises a one-cycle error and produces no beats. Channel handshakes, data and 4 KB page limits belong to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: The kind code `kind_i` uses these values: 2'b00 is fixed, 2'b01 is incrementing, 2'b10 is wrapping and 2'b11 is reserved. The reserved value is never accepted.
- R2: An accepted burst has `len_i`+1 beats, numbered 0 to `len_i` on `beat_idx_o`. `beat_last_o` is high only on the beat whose index equals `len_i`.
- R3: The beat width in bytes is 2 to the power `size_i`. A start address whose low `size_i` bits are not all zero is misaligned.
- R4: On an incrementing burst, each consumed beat adds the beat width to `beat_addr_o`.
- R5: On a fixed burst, every beat shows the start address.
- R6: On a wrapping burst, `wrap_lo_o` holds the start address minus (start modulo total), where total is (`len_i`+1) times the beat width. `wrap_hi_o` holds `wrap_lo_o` + total − 1. Both read 0 when no wrapping burst is active.
- R7: On a wrapping burst, when the address after a step would be above `wrap_hi_o`, the next beat address is `wrap_lo_o` instead.
- R8: A wrapping request with a misaligned start address is refused.
- R9: A refused request (reserved kind or R8) drives `err_o` high for exactly the one cycle after the start pulse. No beat becomes valid.
- R10: `start_i` is ignored while a burst is active, and `step_i` is ignored while idle.
- R11: The cycle after the final beat is stepped, `beat_valid_o` is low. A start pulse in that later cycle is accepted.
- R12: After reset the block is idle. `beat_valid_o`, `err_o`, `beat_addr_o`, `wrap_lo_o` and `wrap_hi_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; sampled only while idle |
| addr_i | input | ADDR_W | Start address of the request |
| len_i | input | 4 | Beats minus one |
| size_i | input | 3 | Log2 of the beat width in bytes |
| kind_i | input | 2 | Burst kind code (R1) |
| step_i | input | 1 | Consume the current beat |
| beat_valid_o | output | 1 | A beat address is presented |
| beat_addr_o | output | ADDR_W | Address of the current beat |
| beat_idx_o | output | 4 | Index of the current beat |
| beat_last_o | output | 1 | The current beat is the final one |
| err_o | output | 1 | One-cycle refusal flag |
| wrap_lo_o | output | ADDR_W | Lower bound of the wrap window |
| wrap_hi_o | output | ADDR_W | Upper bound of the wrap window |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the consumption of the final beat together with a new start pulse. The second pair is a wrapping step back to the lower bound on the very beat that is last. For the first pair, the bench holds `start_i` high, with a reserved kind, through whole bursts, including the final step. It then judges that the burst's addresses were not disturbed, that no error was raised, and that the block is idle the cycle after. Wrapping bursts whose start lies in the upper part of the window force the return to the lower bound to occur at various beat positions. Each address is compared with a modulo formula the bench computes itself.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int LEN_W  = 4;
  localparam int SIZE_W = 3;
  localparam int TOT_W  = 12;

  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

  function automatic logic [TOT_W-1:0] beat_bytes(input logic [SIZE_W-1:0] size);
    return TOT_W'(1) << size;
  endfunction

  function automatic logic [TOT_W-1:0] burst_total(input logic [LEN_W-1:0] len,
                                                   input logic [SIZE_W-1:0] size);
    return (TOT_W'(len) + TOT_W'(1)) << size;
  endfunction
endpackage

// File: rtl/burst_decode.sv
module burst_decode import burst_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        kind_i,
  output logic              bad_o,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  function automatic logic [ADDR_W-1:0] window_low(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] tot);
    return a - (a % tot);
  endfunction

  logic [ADDR_W-1:0] tot_w;
  logic [ADDR_W-1:0] width_w;
  logic              misaligned;

  assign tot_w      = ADDR_W'(burst_total(len_i, size_i));
  assign width_w    = ADDR_W'(beat_bytes(size_i));
  assign misaligned = (addr_i & (width_w - ADDR_W'(1))) != '0;
  assign lo_o       = window_low(addr_i, tot_w);
  assign hi_o       = lo_o + tot_w - ADDR_W'(1);
  assign bad_o      = (kind_i == BK_RSVD) || ((kind_i == BK_WRAP) && misaligned);
endmodule

// File: rtl/burst_next.sv
module burst_next import burst_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              wrapped_o
);
  logic [ADDR_W:0] sum_x;

  assign sum_x     = {1'b0, cur_i} + (ADDR_W+1)'(beat_bytes(size_i));
  assign wrapped_o = (kind_i == BK_WRAP) && (sum_x > {1'b0, hi_i});

  always_comb begin
    unique case (kind_i)
      BK_FIXED: nxt_o = cur_i;
      BK_WRAP:  nxt_o = wrapped_o ? lo_i : sum_x[ADDR_W-1:0];
      default:  nxt_o = sum_x[ADDR_W-1:0];
    endcase
  end
endmodule

// File: rtl/burst_beat_count.sv
module burst_beat_count import burst_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             adv_i,
  output logic [LEN_W-1:0] idx_o,
  output logic             last_o
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o <= '0;
      len_q <= '0;
    end else if (load_i) begin
      idx_o <= '0;
      len_q <= len_i;
    end else if (adv_i) begin
      idx_o <= idx_o + LEN_W'(1);
    end
  end

  assign last_o = (idx_o == len_q);

  a_r2_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o <= len_q);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen import burst_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        kind_i,
  input  logic              step_i,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [3:0]        beat_idx_o,
  output logic              beat_last_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] wrap_lo_o,
  output logic [ADDR_W-1:0] wrap_hi_o
);
  logic              active_q, err_q;
  logic [ADDR_W-1:0] cur_q, lo_q, hi_q;
  logic [SIZE_W-1:0] size_q;
  logic [1:0]        kind_q;

  logic              bad_w, last_w, wrapped_w;
  logic [ADDR_W-1:0] lo_w, hi_w, nxt_w;
  logic [LEN_W-1:0]  idx_w;

  // named internal events
  logic take_start, accept, reject, take_step, finish;
  assign take_start = start_i && !active_q;
  assign reject     = take_start && bad_w;
  assign accept     = take_start && !bad_w;
  assign take_step  = step_i && active_q;
  assign finish     = take_step && last_w;

  burst_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .len_i(len_i), .size_i(size_i), .kind_i(kind_i),
    .bad_o(bad_w), .lo_o(lo_w), .hi_o(hi_w));

  burst_next #(.ADDR_W(ADDR_W)) u_nxt (
    .cur_i(cur_q), .size_i(size_q), .kind_i(kind_q), .lo_i(lo_q), .hi_i(hi_q),
    .nxt_o(nxt_w), .wrapped_o(wrapped_w));

  burst_beat_count u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .len_i(len_i),
    .adv_i(take_step && !last_w), .idx_o(idx_w), .last_o(last_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      cur_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      size_q   <= '0;
      kind_q   <= BK_FIXED;
    end else begin
      err_q <= reject;
      if (accept) begin
        active_q <= 1'b1;
        cur_q    <= addr_i;
        size_q   <= size_i;
        kind_q   <= kind_i;
        lo_q     <= (kind_i == BK_WRAP) ? lo_w : '0;
        hi_q     <= (kind_i == BK_WRAP) ? hi_w : '0;
      end else if (take_step) begin
        cur_q <= nxt_w;
        if (last_w) active_q <= 1'b0;
      end
    end
  end

  logic wrap_on;
  assign wrap_on      = active_q && (kind_q == BK_WRAP);
  assign beat_valid_o = active_q;
  assign beat_addr_o  = active_q ? cur_q : '0;
  assign beat_idx_o   = active_q ? idx_w : '0;
  assign beat_last_o  = active_q && last_w;
  assign err_o        = err_q;
  assign wrap_lo_o    = wrap_on ? lo_q : '0;
  assign wrap_hi_o    = wrap_on ? hi_q : '0;

  a_r9_refuse_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err_o && !beat_valid_o);
  a_r1_rsvd_refused: assert property (@(posedge clk) disable iff (!rst_n)
    take_start && kind_i == BK_RSVD |=> err_o);
  a_r5_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    take_step && !last_w && kind_q == BK_FIXED |=> $stable(beat_addr_o));
  a_r4_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
    take_step && !last_w && kind_q == BK_INCR
    |=> beat_addr_o == $past(beat_addr_o) + ADDR_W'(beat_bytes($past(size_q))));
  a_r7_wrap_inside: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_on |-> (beat_addr_o >= wrap_lo_o) && (beat_addr_o <= wrap_hi_o));
  a_r7_wrap_return: assert property (@(posedge clk) disable iff (!rst_n)
    take_step && !last_w && wrapped_w |=> beat_addr_o == $past(wrap_lo_o));
  a_r11_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !beat_valid_o);
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && start_i && !finish |=> beat_valid_o && !err_o);
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, step_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [3:0]  len_i = '0;
  logic [2:0]  size_i = '0;
  logic [1:0]  kind_i = '0;
  logic        beat_valid_o, beat_last_o, err_o;
  logic [31:0] beat_addr_o, wrap_lo_o, wrap_hi_o;
  logic [3:0]  beat_idx_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(32)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int tot_of(input int len, input int size);
    return (len + 1) * (1 << size);
  endfunction

  function automatic logic [31:0] lo_of(input logic [31:0] a, input int len, input int size);
    logic [31:0] t = 32'(tot_of(len, size));
    return a - (a % t);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input int len, input int size,
                                           input int kind, input int i);
    logic [31:0] w = 32'(1 << size);
    logic [31:0] t = 32'(tot_of(len, size));
    logic [31:0] lo = lo_of(a, len, size);
    case (kind)
      0: return a;
      1: return a + w * 32'(i);
      default: return lo + (((a - lo) + w * 32'(i)) % t);
    endcase
  endfunction

  function automatic bit refused(input logic [31:0] a, input int size, input int kind);
    return (kind == 3) || (kind == 2 && (a % (32'd1 << size)) != 0);
  endfunction

  // poke: hold start_i high with a reserved request through the whole burst
  task automatic run_burst(input logic [31:0] a, input int len, input int size,
                           input int kind, input bit poke);
    int i;
    string tag;
    @(negedge clk);
    start_i = 1; addr_i = a; len_i = 4'(len); size_i = 3'(size); kind_i = 2'(kind);
    @(negedge clk);
    start_i = poke; kind_i = poke ? 2'b11 : kind_i; addr_i = ~a;
    if (refused(a, size, kind)) begin
      start_i = 0;
      tag = (kind == 3) ? "R1 R9 reserved refused" : "R8 R9 misaligned wrap refused";
      chk(tag, {31'b0, err_o}, 1);
      chk("R9 no beat on refusal", {31'b0, beat_valid_o}, 0);
      @(negedge clk);
      chk("R9 err one cycle", {31'b0, err_o}, 0);
      chk("R9 still idle", {31'b0, beat_valid_o}, 0);
      return;
    end
    tag = (kind == 0) ? "R5 fixed addr" : (kind == 1) ? "R4 R3 incr addr" : "R7 wrap addr";
    i = 0;
    while (i <= len) begin
      bit st = ($urandom % 4) != 0;
      chk("R2 beat valid", {31'b0, beat_valid_o}, 1);
      chk(tag, beat_addr_o, exp_addr(a, len, size, kind, i));
      chk("R2 beat index", {28'b0, beat_idx_o}, 32'(i));
      chk("R2 last flag", {31'b0, beat_last_o}, {31'b0, i == len});
      chk("R10 err quiet while active", {31'b0, err_o}, 0);
      if (kind == 2) begin
        chk("R6 wrap lo", wrap_lo_o, lo_of(a, len, size));
        chk("R6 wrap hi", wrap_hi_o, lo_of(a, len, size) + 32'(tot_of(len, size)) - 1);
      end else begin
        chk("R6 lo zero off wrap", wrap_lo_o, 0);
        chk("R6 hi zero off wrap", wrap_hi_o, 0);
      end
      step_i = st;
      @(negedge clk);
      if (st) i++;
    end
    step_i = 0;
    start_i = 0;
    chk("R11 idle after last", {31'b0, beat_valid_o}, 0);
    chk("R10 no err from ignored start", {31'b0, err_o}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R12 reset valid", {31'b0, beat_valid_o}, 0);
    chk("R12 reset err", {31'b0, err_o}, 0);
    chk("R12 reset addr", beat_addr_o, 0);
    chk("R12 reset lo", wrap_lo_o, 0);
    chk("R12 reset hi", wrap_hi_o, 0);
    rst_n = 1;
    @(negedge clk);
    step_i = 1;
    repeat (2) @(negedge clk);
    chk("R10 step ignored idle", {31'b0, beat_valid_o}, 0);
    chk("R10 step idle addr", beat_addr_o, 0);
    step_i = 0;

    run_burst(32'h38, 3, 2, 2, 0);        // R7 wraps 38,3c,30,34
    run_burst(32'h5, 2, 0, 2, 0);         // R6 non power window 3..5
    run_burst(32'h100, 15, 7, 1, 0);      // R4 largest incr
    run_burst(32'h77, 0, 0, 0, 0);        // R2 single beat
    run_burst(32'h1000, 4, 3, 0, 1);      // R10 R11 start held throughout
    run_burst(32'h7c, 7, 2, 2, 1);        // R7 wrap with start held
    run_burst(32'h40, 3, 0, 3, 0);        // R1 reserved
    run_burst(32'h42, 3, 2, 2, 0);        // R8 misaligned
    // R11: start right after last beat consumed is accepted
    run_burst(32'h200, 1, 1, 1, 0);
    run_burst(32'h300, 1, 1, 1, 0);

    for (int n = 0; n < 60; n++) begin
      int k = $urandom % 8;
      int sz = $urandom % 8;
      int ln = $urandom % 16;
      logic [31:0] a = $urandom;
      int kind = (k < 2) ? 0 : (k < 4) ? 1 : (k < 7) ? 2 : 3;
      if (kind == 2 && ($urandom % 8) != 0) a = a & ~((32'd1 << sz) - 1);
      run_burst(a, ln, sz, kind, ($urandom % 4) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule